// File: doc/BRIEF.md
# Indirect Vector-Table Access Port

This block sits between a register master and a downstream device register port. Two of the device's registers form an indirect access pair: a 32-bit data register at offset 0x70 and a 32-bit address register at offset 0x74. Software writes an address word that selects a target type and an offset, and then moves data through the data register. When the address word selects the interrupt vector table, the block serves the access from a local table RAM instead of the device. It also synthesises the completion handshake the protocol expects, so software sees its latch and commit steps finish.

Every other register offset, and every address word that selects another type, passes straight through to the downstream port. The block accepts one request at a time. It answers each request with a single-cycle response pulse carrying read data and an error flag.

The controller has four states:
- `S_IDLE` accepts a request. It moves to `S_REPLY` for errors and for locally served latch reads and commits, to `S_TBL_READ` for table reads, and to `S_DN_WAIT` for anything forwarded.
- `S_DN_WAIT` holds until the downstream completion and then moves to `S_REPLY`.
- `S_TBL_READ` spends one cycle on the RAM read and then moves to `S_REPLY`.
- `S_REPLY` raises the response for one cycle and returns to `S_IDLE`.

Top module: `vec_window_port`

## Requirements
- R1: An address-register word whose bits 30:16 equal 0x0001 (word & 0x7FFF0000 == 0x00010000) selects the vector table. Such a write sets the enabled flag and stores the whole 32-bit word. Bits 15:12 of the word are a byte mask and are ignored.
- R2: Every address-register write first clears the enabled flag. A word that does not select the table is forwarded downstream, whatever its bit 31, and leaves the flag clear, so later register reads go downstream.
- R3: A table-selecting address write with bit 31 set is a commit. It writes the last captured data word into table entry bits 11:2 of the word, ignoring bits 1:0. It is not forwarded, and it is answered without error one cycle after acceptance.
- R4: A table-selecting address write with bit 31 clear is stored and is also forwarded downstream.
- R5: While enabled, a read of the address register returns the stored word with bit 31 inverted. No downstream access takes place.
- R6: While enabled, a read of the data register returns the table entry indexed by bits 11:2 of the stored word. No downstream access takes place.
- R7: An aligned 32-bit write to the data register captures the value locally and is also forwarded downstream.
- R8: An access whose start address falls in 0x70..0x77 with a size other than 4 bytes, or with address bits 1:0 non-zero, gets an error response. It has no effect and is not forwarded.
- R9: Accesses to any other offset, of any size, are forwarded with their address, size and data unchanged. A read returns the downstream data. A forwarded write returns zero.
- R10: After reset the enabled flag is clear and the captured data word is zero, so reads of both registers go downstream.
- R11: `up_ready` is high only in the idle state. Each accepted request produces exactly one single-cycle `up_rvalid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Request present |
| up_ready | output | 1 | Block idle, request accepted this cycle |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Byte offset of the access |
| up_size | input | 3 | Access size in bytes |
| up_wdata | input | 32 | Write data |
| up_rvalid | output | 1 | One-cycle response strobe |
| up_rdata | output | 32 | Response read data (zero for writes) |
| up_err | output | 1 | Response error flag |
| dn_valid | output | 1 | Forwarded request strobe |
| dn_write | output | 1 | Forwarded direction |
| dn_addr | output | ADDR_W | Forwarded byte offset |
| dn_size | output | 3 | Forwarded size in bytes |
| dn_wdata | output | 32 | Forwarded write data |
| dn_done | input | 1 | Downstream completion strobe |
| dn_rdata | input | 32 | Downstream read data, valid with dn_done |

## Verification
The assertions assume that the downstream port raises `dn_done` exactly once per forwarded request and only while the block waits for it. They also assume that `up_size` is a plain byte count. The bench's downstream model answers each forwarded request exactly two cycles after it, and the stimulus only issues a request while `up_ready` is high, keeping one request in flight. Table entries are read back only after they have been committed, so the uninitialised RAM never reaches a compared value.

// File: rtl/vwp_pkg.sv
package vwp_pkg;

    localparam logic [31:0] TYPE_FIELD_MASK = 32'h7FFF_0000;
    localparam logic [31:0] TYPE_VECTOR_TBL = 32'h0001_0000;
    localparam logic [31:0] LATCH_FLAG      = 32'h8000_0000;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DN_WAIT,
        S_TBL_READ,
        S_REPLY
    } vwp_state_e;

    typedef enum logic [2:0] {
        CL_PASS,
        CL_ERR,
        CL_DATA_WR,
        CL_DATA_RD,
        CL_ADDR_RD,
        CL_ADDR_COMMIT,
        CL_ADDR_WR
    } vwp_class_e;

endpackage

// File: rtl/vwp_decode.sv
module vwp_decode
    import vwp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_OFF = 'h70,
    parameter logic [ADDR_W-1:0] ADDR_OFF = 'h74
) (
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [15:0]       wtop,
    input  logic              enabled,
    output vwp_class_e        cls,
    output logic              type_hit
);

    logic on_data, on_addr, bad_shape;

    always_comb begin
        on_data   = (addr[ADDR_W-1:2] == DATA_OFF[ADDR_W-1:2]);
        on_addr   = (addr[ADDR_W-1:2] == ADDR_OFF[ADDR_W-1:2]);
        bad_shape = (size != 3'd4) || (addr[1:0] != 2'b00);
        type_hit  = ({wtop, 16'h0000} & TYPE_FIELD_MASK) == TYPE_VECTOR_TBL;

        cls = CL_PASS;
        if ((on_data || on_addr) && bad_shape) begin
            cls = CL_ERR;
        end else if (on_addr && is_write) begin
            cls = (type_hit && wtop[15]) ? CL_ADDR_COMMIT : CL_ADDR_WR;
        end else if (on_addr) begin
            cls = enabled ? CL_ADDR_RD : CL_PASS;
        end else if (on_data && is_write) begin
            cls = CL_DATA_WR;
        end else if (on_data) begin
            cls = enabled ? CL_DATA_RD : CL_PASS;
        end
    end

endmodule

// File: rtl/vwp_table_ram.sv
module vwp_table_ram #(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic             re,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[widx] <= wdata;
        end
        if (re) begin
            rdata <= mem[ridx];
        end
    end

endmodule

// File: rtl/vec_window_port.sv
module vec_window_port
    import vwp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DATA_OFF = 'h70,
    parameter logic [ADDR_W-1:0] ADDR_OFF = 'h74,
    parameter int TBL_DEPTH = 1024,
    localparam int IDX_W = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_write,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [2:0]        up_size,
    input  logic [31:0]       up_wdata,
    output logic              up_rvalid,
    output logic [31:0]       up_rdata,
    output logic              up_err,
    output logic              dn_valid,
    output logic              dn_write,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [2:0]        dn_size,
    output logic [31:0]       dn_wdata,
    input  logic              dn_done,
    input  logic [31:0]       dn_rdata
);

    vwp_state_e  state_q, state_d;
    vwp_class_e  cls;
    logic        type_hit;
    logic        enabled_q;
    logic [31:0] stored_q;
    logic [31:0] capt_q;
    logic [31:0] reply_q;
    logic        err_q;
    logic        fwd_wr_q;
    logic        accept;
    logic        forward;
    logic [31:0] ram_rdata;

    vwp_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_OFF(DATA_OFF),
        .ADDR_OFF(ADDR_OFF)
    ) u_decode (
        .is_write(up_write),
        .addr    (up_addr),
        .size    (up_size),
        .wtop    (up_wdata[31:16]),
        .enabled (enabled_q),
        .cls     (cls),
        .type_hit(type_hit)
    );

    assign accept  = (state_q == S_IDLE) && up_valid;
    assign forward = (cls == CL_PASS) || (cls == CL_DATA_WR) || (cls == CL_ADDR_WR);

    vwp_table_ram #(
        .DEPTH(TBL_DEPTH)
    ) u_table (
        .clk  (clk),
        .we   (accept && (cls == CL_ADDR_COMMIT)),
        .widx (up_wdata[IDX_W+1:2]),
        .wdata(capt_q),
        .re   (accept && (cls == CL_DATA_RD)),
        .ridx (stored_q[IDX_W+1:2]),
        .rdata(ram_rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (up_valid) begin
                    if (forward) begin
                        state_d = S_DN_WAIT;
                    end else if (cls == CL_DATA_RD) begin
                        state_d = S_TBL_READ;
                    end else begin
                        state_d = S_REPLY;
                    end
                end
            end
            S_DN_WAIT:  if (dn_done) state_d = S_REPLY;
            S_TBL_READ: state_d = S_REPLY;
            S_REPLY:    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        up_ready  = (state_q == S_IDLE);
        up_rvalid = (state_q == S_REPLY);
        up_rdata  = reply_q;
        up_err    = err_q;
        dn_valid  = accept && forward;
        dn_write  = up_write;
        dn_addr   = up_addr;
        dn_size   = up_size;
        dn_wdata  = up_wdata;
    end

    // Window state and reply data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled_q <= 1'b0;
            stored_q  <= '0;
            capt_q    <= '0;
            reply_q   <= '0;
            err_q     <= 1'b0;
            fwd_wr_q  <= 1'b0;
        end else begin
            if (accept) begin
                err_q    <= (cls == CL_ERR);
                fwd_wr_q <= up_write;
                reply_q  <= '0;
                if (cls == CL_ADDR_RD) begin
                    reply_q <= stored_q ^ LATCH_FLAG;
                end
                if (cls == CL_DATA_WR) begin
                    capt_q <= up_wdata;
                end
                if ((cls == CL_ADDR_WR) || (cls == CL_ADDR_COMMIT)) begin
                    enabled_q <= type_hit;
                    if (type_hit) begin
                        stored_q <= up_wdata;
                    end
                end
            end
            if ((state_q == S_DN_WAIT) && dn_done) begin
                reply_q <= fwd_wr_q ? 32'h0 : dn_rdata;
            end
            if (state_q == S_TBL_READ) begin
                reply_q <= ram_rdata;
            end
        end
    end

    // Checks
    logic on_window, shape_bad, req_table;
    assign on_window = (up_addr[ADDR_W-1:3] == DATA_OFF[ADDR_W-1:3]);
    assign shape_bad = (up_size != 3'd4) || (up_addr[1:0] != 2'b00);
    assign req_table = (up_wdata[30:16] == 15'h0001);

    assert_reply_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |=> !up_rvalid);

    assert_busy_in_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |-> !up_ready);

    assert_commit_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && up_write && on_window && up_addr[2] && !shape_bad
         && req_table && up_wdata[31]) |-> !dn_valid ##1 (up_rvalid && !up_err));

    assert_bad_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && on_window && shape_bad)
        |-> !dn_valid ##1 (up_rvalid && up_err));

    assert_other_forwarded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && !on_window) |-> dn_valid);

    assert_no_fwd_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !up_ready |-> !dn_valid);

endmodule

// File: tb/vec_window_port_bench.sv
module vec_window_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic        up_write = 1'b0;
    logic [7:0]  up_addr = '0;
    logic [2:0]  up_size = 3'd4;
    logic [31:0] up_wdata = '0;
    logic        up_rvalid;
    logic [31:0] up_rdata;
    logic        up_err;
    logic        dn_valid;
    logic        dn_write;
    logic [7:0]  dn_addr;
    logic [2:0]  dn_size;
    logic [31:0] dn_wdata;
    logic        dn_done = 1'b0;
    logic [31:0] dn_rdata = '0;

    always #10 clk = ~clk;

    vec_window_port u_vec_window_port (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_write(up_write),
        .up_addr(up_addr), .up_size(up_size), .up_wdata(up_wdata),
        .up_rvalid(up_rvalid), .up_rdata(up_rdata), .up_err(up_err),
        .dn_valid(dn_valid), .dn_write(dn_write), .dn_addr(dn_addr),
        .dn_size(dn_size), .dn_wdata(dn_wdata),
        .dn_done(dn_done), .dn_rdata(dn_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit in_access = 1'b0;

    // Reference state
    bit          m_en = 1'b0;
    logic [31:0] m_st = '0;
    logic [31:0] m_cap = '0;
    logic [31:0] m_tbl [int];

    // Downstream model: fixed two-cycle latency
    logic [43:0] fwd_q [$];
    int          dn_pend = 0;
    logic [7:0]  dn_pend_addr = '0;

    function automatic logic [31:0] dn_val(input logic [7:0] a);
        return 32'hD500_0000 | {24'h0, a};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (dn_valid) begin
            fwd_q.push_back({dn_write, dn_size, dn_addr, dn_wdata});
            dn_pend = 2;
            dn_pend_addr = dn_addr;
        end
    end

    always @(negedge clk) begin
        dn_done = 1'b0;
        if (dn_pend > 0) begin
            dn_pend--;
            if (dn_pend == 0) begin
                dn_done  = 1'b1;
                dn_rdata = dn_val(dn_pend_addr);
            end
        end
        if (rst_n && up_rvalid && !in_access) begin
            errors++;
            $display("FAIL R11: unexpected response strobe, actual 1 expected 0");
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                          input logic [31:0] wd, input string req);
        logic [31:0] exp_data = 32'h0;
        bit          exp_err = 1'b0;
        bit          exp_fwd = 1'b0;
        bit          on_d = (a[7:2] == 6'h1C);
        bit          on_a = (a[7:2] == 6'h1D);
        bit          hit = ((wd & 32'h7FFF_0000) == 32'h0001_0000);
        bit          got = 1'b0;
        logic [43:0] rec;

        if ((on_d || on_a) && (sz != 3'd4 || a[1:0] != 2'b00)) begin
            exp_err = 1'b1;
        end else if (on_a && wr) begin
            m_en = hit;
            if (hit) m_st = wd;
            if (hit && wd[31]) m_tbl[int'(wd[11:2])] = m_cap;
            else exp_fwd = 1'b1;
        end else if (on_a) begin
            if (m_en) exp_data = m_st ^ 32'h8000_0000;
            else begin exp_fwd = 1'b1; exp_data = dn_val(a); end
        end else if (on_d && wr) begin
            m_cap = wd;
            exp_fwd = 1'b1;
        end else if (on_d) begin
            if (m_en) exp_data = m_tbl[int'(m_st[11:2])];
            else begin exp_fwd = 1'b1; exp_data = dn_val(a); end
        end else begin
            exp_fwd = 1'b1;
            if (!wr) exp_data = dn_val(a);
        end

        fwd_q.delete();
        @(negedge clk);
        chk(up_ready == 1'b1, "R11", "ready before request", 64'(up_ready), 64'd1);
        in_access = 1'b1;
        up_valid = 1'b1; up_write = wr; up_addr = a; up_size = sz; up_wdata = wd;
        @(negedge clk);
        up_valid = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (up_rvalid) begin got = 1'b1; break; end
            @(negedge clk);
        end
        chk(got, req, "response seen", 64'(got), 64'd1);
        if (got) begin
            chk(up_err == exp_err, req, "error flag", 64'(up_err), 64'(exp_err));
            chk(up_rdata == exp_data, req, "response data", 64'(up_rdata), 64'(exp_data));
        end
        chk(fwd_q.size() == int'(exp_fwd), req, "forward count",
            64'(fwd_q.size()), 64'(exp_fwd));
        if (exp_fwd && fwd_q.size() == 1) begin
            rec = fwd_q[0];
            chk(rec == {wr, sz, a, wd}, req, "forwarded request", 64'(rec),
                64'({wr, sz, a, wd}));
        end
        @(negedge clk);
        in_access = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(up_ready == 1'b1 && up_rvalid == 1'b0, "R10", "idle after reset",
            64'({up_ready, up_rvalid}), 64'b10);

        access(1'b0, 8'h74, 3'd4, 32'h0, "R10");               // disabled: address read goes out
        access(1'b0, 8'h70, 3'd4, 32'h0, "R10");               // disabled: data read goes out
        access(1'b1, 8'h70, 3'd4, 32'hCAFE_0001, "R7");        // capture + forward
        access(1'b1, 8'h74, 3'd4, 32'h8001_F008, "R3");        // commit to entry 2, mask ignored
        access(1'b0, 8'h74, 3'd4, 32'h0, "R5");                // completed write reads bit31 clear
        access(1'b1, 8'h74, 3'd4, 32'h0001_0008, "R4");        // latch read, forwarded
        access(1'b0, 8'h74, 3'd4, 32'h0, "R5");                // latched read reports bit31 set
        access(1'b0, 8'h70, 3'd4, 32'h0, "R6");                // table entry 2
        access(1'b1, 8'h70, 3'd4, 32'h1234_5678, "R7");
        access(1'b1, 8'h74, 3'd4, 32'h8001_000B, "R3");        // low offset bits ignored -> entry 2
        access(1'b1, 8'h74, 3'd4, 32'h0001_0008, "R1");
        access(1'b0, 8'h70, 3'd4, 32'h0, "R6");
        access(1'b1, 8'h70, 3'd2, 32'hFFFF_FFFF, "R8");        // wrong size, no capture
        access(1'b0, 8'h76, 3'd4, 32'h0, "R8");                // misaligned
        access(1'b1, 8'h74, 3'd1, 32'h8001_0000, "R8");        // no commit
        access(1'b1, 8'h74, 3'd4, 32'h8001_0FFC, "R3");        // last entry gets 0x12345678
        access(1'b1, 8'h74, 3'd4, 32'h0001_0FFC, "R1");
        access(1'b0, 8'h70, 3'd4, 32'h0, "R6");
        access(1'b1, 8'h74, 3'd4, 32'h8003_0FFC, "R2");        // other type with bit31: forwarded
        access(1'b0, 8'h74, 3'd4, 32'h0, "R2");                // now disabled: goes downstream
        access(1'b0, 8'h70, 3'd4, 32'h0, "R2");
        access(1'b1, 8'h74, 3'd4, 32'h0001_0008, "R1");        // re-enable
        access(1'b1, 8'h74, 3'd4, 32'h0002_0008, "R2");        // type 2 clears enable
        access(1'b0, 8'h74, 3'd4, 32'h0, "R2");
        access(1'b0, 8'h10, 3'd2, 32'h0, "R9");
        access(1'b1, 8'h6E, 3'd1, 32'h0000_00A5, "R9");
        access(1'b0, 8'h78, 3'd4, 32'h0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL R11: watchdog expired, actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule